// File: doc/BRIEF.md
# Per-Pin Direction Configuration Array

This block sits between a tester's vector engine and the pads that reach a device under test. Each of its pins holds a 2-bit mode that sets how the pin behaves. The four modes are a driven output, a sensed input, a bidirectional pin whose direction changes every cycle, and an unused pin. All modes are loaded together from one wide configuration word, and only while a load enable is high.

In each cycle the block applies a stimulus vector. On the pad side it produces output data and output-enable combinationally from that vector and the stored modes. It also registers the sensed pad values into a result vector one clock later. A bidirectional pin in the lower half of the array takes its direction from the stimulus bit one half-array above it. The upper half of the stimulus vector therefore serves as a direction lane, and only lower-half pins can act as bidirectional.

Top module: `pin_dir_array`

## Requirements
- R1: After reset, every pin mode is 11 (unused), every pad_oe bit is 0, every pad_out bit is 0 and result is 0.
- R2: On a rising clock edge with cfg_en high, pin i takes its mode from cfg_data[2i+1:2i]. With cfg_en low, no mode changes, whatever cfg_data holds.
- R3: Mode 00 (output): pad_oe[i] is 1 and pad_out[i] equals stim[i] in the same cycle. result[i] is 0 after the next edge.
- R4: Mode 01 (input): pad_oe[i] is 0 and pad_out[i] is 0 for any stim[i]. result[i] equals pad_in[i] after the next edge.
- R5: Mode 10 on pin i below NUM_PINS/2: stim[i+NUM_PINS/2] is the direction. A 1 gives the behaviour of R3 for that cycle, and a 0 gives the behaviour of R4 for that cycle.
- R6: Mode 11 (unused): pad_oe[i] is 0, pad_out[i] is 0 and result[i] is 0.
- R7: Mode 10 on pin i at or above NUM_PINS/2 behaves as mode 11.
- R8: pad_out[i] is 0 whenever pad_oe[i] is 0.
- R9: result is registered. Its value after a rising edge reflects pad_in, stim and the modes present during the cycle before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Design clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Load strobe for all pin modes |
| cfg_data | input | 2*NUM_PINS | Mode word, pin i at bits 2i+1:2i |
| stim | input | NUM_PINS | Stimulus vector; upper half doubles as bidirectional direction lane |
| pad_in | input | NUM_PINS | Values sensed at the pads |
| pad_out | output | NUM_PINS | Data toward the pads |
| pad_oe | output | NUM_PINS | Pad drive enables |
| result | output | NUM_PINS | Registered captured pad values |

## Verification
pad_out and pad_oe are due in the same cycle that stim is applied. result is due one rising edge later. A mode write takes effect on the edge where cfg_en is sampled high. The driver sets inputs on the falling edge and checks the pad-side outputs just after. It pushes the expected result into a queue, and the monitor pops and compares it shortly after the following rising edge. This way each result is matched against the stimulus of exactly one cycle earlier.

// File: rtl/pdca_pkg.sv
package pdca_pkg;
  typedef enum logic [1:0] {
    PM_DRIVE = 2'b00,
    PM_SENSE = 2'b01,
    PM_SWING = 2'b10,
    PM_IDLE  = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/pdca_rst_sync.sv
module pdca_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pdca_cfg_bank.sv
module pdca_cfg_bank #(
  parameter int NUM_PINS = 96,
  localparam int CW = 2 * NUM_PINS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic [CW-1:0] cfg_data,
  output logic [CW-1:0] cfg_q
);
  logic [CW-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_en) cfg_d = cfg_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '1;
    else        cfg_q <= cfg_d;
  end
endmodule

// File: rtl/pdca_pin_cell.sv
module pdca_pin_cell
  import pdca_pkg::*;
#(
  parameter bit BIDIR_OK = 1'b1
) (
  input  logic [1:0] mode,
  input  logic       stim_bit,
  input  logic       dir_bit,
  input  logic       pad_in,
  output logic       pad_out,
  output logic       pad_oe,
  output logic       cap
);
  logic drive;
  logic sense;

  always_comb begin
    drive = 1'b0;
    sense = 1'b0;
    case (pin_mode_e'(mode))
      PM_DRIVE: drive = 1'b1;
      PM_SENSE: sense = 1'b1;
      PM_SWING: begin
        drive = BIDIR_OK & dir_bit;
        sense = BIDIR_OK & ~dir_bit;
      end
      default: ;
    endcase
    pad_oe  = drive;
    pad_out = drive & stim_bit;
    cap     = sense & pad_in;
  end
endmodule

// File: rtl/pin_dir_array.sv
module pin_dir_array #(
  parameter int NUM_PINS = 96,
  localparam int HALF = NUM_PINS / 2,
  localparam int CW   = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_en,
  input  logic [CW-1:0]       cfg_data,
  input  logic [NUM_PINS-1:0] stim,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] result
);
  logic                rst_n_sync;
  logic [CW-1:0]       cfg_q;
  logic [NUM_PINS-1:0] cap_d;
  logic [NUM_PINS-1:0] result_q;

  pdca_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  pdca_cfg_bank #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk(clk), .rst_n(rst_n_sync), .cfg_en(cfg_en),
    .cfg_data(cfg_data), .cfg_q(cfg_q)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    if (i < HALF) begin : g_lo
      pdca_pin_cell #(.BIDIR_OK(1'b1)) u_cell (
        .mode(cfg_q[2*i +: 2]), .stim_bit(stim[i]), .dir_bit(stim[i+HALF]),
        .pad_in(pad_in[i]), .pad_out(pad_out[i]), .pad_oe(pad_oe[i]),
        .cap(cap_d[i])
      );
    end else begin : g_hi
      pdca_pin_cell #(.BIDIR_OK(1'b0)) u_cell (
        .mode(cfg_q[2*i +: 2]), .stim_bit(stim[i]), .dir_bit(1'b0),
        .pad_in(pad_in[i]), .pad_out(pad_out[i]), .pad_oe(pad_oe[i]),
        .cap(cap_d[i])
      );
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) result_q <= '0;
    else             result_q <= cap_d;
  end

  assign result = result_q;
endmodule

// File: rtl/pin_dir_array_chk.sv
module pin_dir_array_chk #(
  parameter int NUM_PINS = 96,
  localparam int CW = 2 * NUM_PINS
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_en,
  input logic [CW-1:0]       cfg_q,
  input logic [NUM_PINS-1:0] pad_in,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] result
);
  logic cfg_seen_q;
  logic cfg_seen_d;

  always_comb cfg_seen_d = cfg_seen_q | cfg_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_seen_q <= 1'b0;
    else        cfg_seen_q <= cfg_seen_d;
  end

  AST_NO_DRIVE_BEFORE_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_seen_q |-> (pad_oe == '0)); // R1

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_q)); // R2

  AST_DRIVEN_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((result & $past(pad_oe)) == '0)); // R3

  AST_RESULT_FROM_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((result & ~$past(pad_in)) == '0)); // R9

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & ~pad_oe) == '0)); // R8
endmodule

bind pin_dir_array pin_dir_array_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_q(cfg_q),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .result(result)
);

// File: tb/pin_dir_array_tb_top.sv
module pin_dir_array_tb_top;
  localparam int N  = 96;
  localparam int H  = N / 2;
  localparam int CW = 2 * N;

  logic          clk;
  logic          rst_n;
  logic          cfg_en;
  logic [CW-1:0] cfg_data;
  logic [N-1:0]  stim;
  logic [N-1:0]  pad_in;
  logic [N-1:0]  pad_out;
  logic [N-1:0]  pad_oe;
  logic [N-1:0]  result;

  int tests;
  int fails;
  logic [1:0]   mdl [N];
  logic [N-1:0] exp_q [$];
  string        tag_q [$];

  pin_dir_array #(.NUM_PINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_data(cfg_data),
    .stim(stim), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .result(result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [N-1:0] rnd();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Independent model of one cycle
  task automatic model(input logic [N-1:0] s, input logic [N-1:0] p,
                       output logic [N-1:0] eo, output logic [N-1:0] ed,
                       output logic [N-1:0] er);
    eo = '0; ed = '0; er = '0;
    for (int i = 0; i < N; i++) begin
      logic drv, sen;
      drv = 1'b0; sen = 1'b0;
      if (mdl[i] == 2'b00) drv = 1'b1;
      else if (mdl[i] == 2'b01) sen = 1'b1;
      else if (mdl[i] == 2'b10 && i < H) begin
        drv = s[i+H]; sen = ~s[i+H];
      end
      eo[i] = drv;
      ed[i] = drv & s[i];
      er[i] = sen & p[i];
    end
  endtask

  task automatic cfg_write(input logic [CW-1:0] w, input logic en);
    @(negedge clk);
    cfg_en = en; cfg_data = w;
    if (en) for (int i = 0; i < N; i++) mdl[i] = w[2*i +: 2];
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  // Driver: applies a cycle, checks pad side now, queues result
  task automatic apply(string req, input logic [N-1:0] s, input logic [N-1:0] p);
    logic [N-1:0] eo, ed, er;
    @(negedge clk);
    stim = s; pad_in = p;
    model(s, p, eo, ed, er);
    #1;
    check({req, " pad_oe"}, pad_oe, eo);
    check({req, " pad_out"}, pad_out, ed);
    exp_q.push_back(er);
    tag_q.push_back(req);
  endtask

  // Monitor: compares result one edge after stimulus
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [N-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " result (R9)"}, result, e);
    end
  end

  function automatic logic [CW-1:0] all_mode(logic [1:0] m);
    logic [CW-1:0] w;
    for (int i = 0; i < N; i++) w[2*i +: 2] = m;
    return w;
  endfunction

  initial begin
    #150000;
    fails++; tests++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [CW-1:0] w;
    tests = 0; fails = 0;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_data = '0; stim = '0; pad_in = '0;
    for (int i = 0; i < N; i++) mdl[i] = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state with busy stimulus
    stim = '1; pad_in = '1;
    #1;
    check("R1 pad_oe", pad_oe, '0);
    check("R1 pad_out", pad_out, '0);
    check("R1 result", result, '0);
    @(negedge clk);
    check("R1 result after edge", result, '0);

    // R2, R3: all outputs
    cfg_write(all_mode(2'b00), 1'b1);
    for (int k = 0; k < 4; k++) apply("R3 output", rnd(), rnd());

    // R4: all inputs
    cfg_write(all_mode(2'b01), 1'b1);
    for (int k = 0; k < 4; k++) apply("R4 input", rnd(), rnd());
    apply("R4 input all ones", '1, '1);

    // R2: write with cfg_en low is ignored (still inputs)
    cfg_write(all_mode(2'b00), 1'b0);
    apply("R2 hold without enable", '1, '1);

    // R5, R7: all bidirectional
    cfg_write(all_mode(2'b10), 1'b1);
    apply("R5 dir drive", '1, '1);
    apply("R5 dir sample", {{H{1'b0}}, {H{1'b1}}}, '1);
    for (int k = 0; k < 4; k++) apply("R5 R7 bidir mix", rnd(), rnd());

    // R6: unused
    cfg_write(all_mode(2'b11), 1'b1);
    apply("R6 unused", '1, '1);
    apply("R6 unused rnd", rnd(), rnd());

    // R8 and mixed per-pin modes, pin field positions per R2
    for (int k = 0; k < 4; k++) begin
      w = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
      cfg_write(w, 1'b1);
      for (int j = 0; j < 3; j++) apply("R2 R8 mixed modes", rnd(), rnd());
    end

    // back-to-back mode change: R9 result uses pre-edge modes
    cfg_write(all_mode(2'b01), 1'b1);
    apply("R9 before switch", '0, '1);
    cfg_write(all_mode(2'b00), 1'b1);
    apply("R9 after switch", '1, '1);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule